// File: doc/BRIEF.md
# Host Register Port for a Line Transceiver

This block is the 8-bit parallel host port of a line transceiver. An external controller reaches a small register file through it. Two strap inputs set the bus style. One strap picks a bus that carries the address and the data on the same eight lines, or a bus with a separate address. The other strap picks separate read and write strobes, or a data strobe with a read/not-write direction line. One pin does two jobs: it is the address-latch strobe on the shared bus and the top address bit on the separate-address bus.

All bus pins are sampled into the core clock domain through a short synchronizer, and every decision is taken on the synchronized copies. Behind the port are several read/write configuration bytes, a sticky event register that drives a single active-low flag, and a fixed identification byte. Every other address reads as zero and ignores writes. A test input releases the data bus and the flag output at once, whatever the bus is doing.

Top module: `hostRegPort`

## Requirements
- R1: With `muxSel` low, the register address is `{aleA7, addrLo}`, so `aleA7` is address bit 7, and `dbIn` carries only write data.
- R2: With `muxSel` high, a rising edge on `aleA7` captures `dbIn` as the address. That address holds until the next rising edge, and `addrLo` has no effect.
- R3: With `busTypeSel` low, `rdDsN` low is a read, and a write commits when `wrRwN` goes from low to high.
- R4: With `busTypeSel` high, `rdDsN` low with `wrRwN` high is a read. A write commits when `rdDsN` goes from low to high while `wrRwN` is low.
- R5: While `csN` is high, a strobe neither drives the bus nor changes any register.
- R6: `dbOe` is 1 only while `csN` is low and the read condition of the selected mode holds, and it returns to 0 once the strobe is released.
- R7: Address 0x0F reads `{ID_VARIANT, ID_CODE, ID_REV}` (bit 7, bits 6:4, bits 3:0). With the default parameters this is 0xA3. Writes to 0x0F are ignored.
- R8: Addresses 0x09 to 0x0E and 0x10 to 0xFF, which include 0xBC to 0xBF, read 0x00 and ignore writes.
- R9: Addresses 0x00 to `NUM_RW-1` are read/write bytes. Each one reads back the last byte written to it and appears on `cfgOut` at bit offset 8 times its address.
- R10: Address 0x08 is a sticky event byte. Each bit is set in any clock cycle in which that bit of `evtIn` is high. Writing a 1 to a bit clears it. `irqN` is low while any bit is set.
- R11: While `testHiZ` is high, `dbOe` and `irqOe` are 0 in the same cycle, even in the middle of a read.
- R12: After reset all read/write bytes and the event byte are 0x00, `dbOe` is 0 and `irqN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all bus pins are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| muxSel | input | 1 | Strap: 1 = shared address/data bus, 0 = separate address |
| busTypeSel | input | 1 | Strap: 0 = read/write strobes, 1 = data strobe plus direction |
| testHiZ | input | 1 | High releases the data bus and the flag output |
| csN | input | 1 | Active-low chip select |
| addrLo | input | 7 | Address bits 6:0 when the address is separate |
| aleA7 | input | 1 | Address-latch strobe (shared bus) or address bit 7 (separate address) |
| rdDsN | input | 1 | Active-low read strobe or data strobe |
| wrRwN | input | 1 | Active-low write strobe or read/not-write |
| dbIn | input | 8 | Data bus as seen by the port |
| dbOut | output | 8 | Read data, zero when not reading |
| dbOe | output | 1 | Drive enable for the data bus |
| evtIn | input | 8 | Event pulses from the core that set the sticky bits |
| cfgOut | output | 8*NUM_RW | Read/write bytes presented to the core |
| irqN | output | 1 | Active-low flag: an event bit is pending |
| irqOe | output | 1 | Drive enable for the flag output |

## Verification
The bench builds the port with a two-stage synchronizer, eight read/write bytes and the default identity 0xA3. With these values the identity, unused and event addresses all sit inside the decoded range, and 0x83 shows the effect of the top address bit. The behavioural model tracks the synchronizer depth with a short history of pin samples. Because of that, the latch edge, the write edge and the release of the bus can all be compared cycle by cycle in each of the four strap combinations. The directed sequence moves through the four combinations with junk on the unused pins, so that a wrong choice of address source, strobe edge or direction shows up as a wrong byte read back.

// File: rtl/hostPortPkg.sv
package hostPortPkg;

  typedef struct packed {
    logic       csN;
    logic       aleA7;
    logic [6:0] addrLo;
    logic       rdDsN;
    logic       wrRwN;
    logic [7:0] data;
  } busPins_t;

  localparam busPins_t PINS_IDLE = '{csN: 1'b1, aleA7: 1'b0, addrLo: 7'h00,
                                     rdDsN: 1'b1, wrRwN: 1'b1, data: 8'h00};

  typedef struct packed {
    logic       wrEn;
    logic [7:0] wrAddr;
    logic [7:0] wrData;
    logic       rdEn;
    logic [7:0] rdAddr;
  } regStrobe_t;

  localparam logic [7:0] ADDR_STATUS = 8'h08;
  localparam logic [7:0] ADDR_ID     = 8'h0F;

endpackage

// File: rtl/hostPortSync.sv
module hostPortSync #(
  parameter int          W      = 8,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= RST;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/hostPortCtrl.sv
module hostPortCtrl
  import hostPortPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       muxSel,
  input  logic       busTypeSel,
  input  busPins_t   pins,
  output regStrobe_t strb
);
  busPins_t   prevPins;
  logic [7:0] latAddr;
  logic       aleRise;
  logic       readCond;
  logic       writeEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPins <= PINS_IDLE;
    else       prevPins <= pins;
  end

  assign aleRise = muxSel && pins.aleA7 && !prevPins.aleA7;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        latAddr <= 8'h00;
    else if (aleRise) latAddr <= pins.data;
  end

  always_comb begin
    if (busTypeSel) begin
      readCond  = !pins.rdDsN && pins.wrRwN;
      writeEdge = pins.rdDsN && !prevPins.rdDsN && !prevPins.wrRwN;
    end else begin
      readCond  = !pins.rdDsN;
      writeEdge = pins.wrRwN && !prevPins.wrRwN;
    end
  end

  always_comb begin
    strb.rdEn   = !pins.csN && readCond;
    strb.rdAddr = muxSel ? latAddr : {pins.aleA7, pins.addrLo};
    strb.wrEn   = !prevPins.csN && writeEdge;
    strb.wrAddr = muxSel ? latAddr : {prevPins.aleA7, prevPins.addrLo};
    strb.wrData = prevPins.data;
  end

  // R3 / R4: a commit is a single-cycle event per strobe release
  a_r3_write_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> !strb.wrEn);

endmodule

// File: rtl/hostPortData.sv
module hostPortData
  import hostPortPkg::*;
#(
  parameter int         NUM_RW     = 8,
  parameter logic       ID_VARIANT = 1'b1,
  parameter logic [2:0] ID_CODE    = 3'b010,
  parameter logic [3:0] ID_REV     = 4'h3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  input  logic [7:0]            evtIn,
  output logic [7:0]            rdData,
  output logic [8*NUM_RW-1:0]   cfgOut,
  output logic                  irqPending
);
  localparam int         IDXW     = (NUM_RW > 1) ? $clog2(NUM_RW) : 1;
  localparam logic [7:0] RW_LIMIT = 8'(NUM_RW);
  localparam logic [7:0] ID_VALUE = {ID_VARIANT, ID_CODE, ID_REV};

  logic [7:0]      regs [NUM_RW];
  logic [7:0]      status;
  logic [7:0]      clrMask;
  logic            wrIsRw;
  logic [IDXW-1:0] wrIdx;
  logic [IDXW-1:0] rdIdx;

  assign wrIsRw  = strb.wrEn && (strb.wrAddr < RW_LIMIT);
  assign wrIdx   = strb.wrAddr[IDXW-1:0];
  assign rdIdx   = strb.rdAddr[IDXW-1:0];
  assign clrMask = (strb.wrEn && strb.wrAddr == ADDR_STATUS) ? strb.wrData : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RW; i++) regs[i] <= 8'h00;
    end else if (wrIsRw) begin
      regs[wrIdx] <= strb.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= 8'h00;
    else       status <= (status & ~clrMask) | evtIn;
  end

  for (genvar g = 0; g < NUM_RW; g++) begin : gCfg
    assign cfgOut[g*8 +: 8] = regs[g];
  end

  always_comb begin
    if (strb.rdAddr < RW_LIMIT)          rdData = regs[rdIdx];
    else if (strb.rdAddr == ADDR_STATUS) rdData = status;
    else if (strb.rdAddr == ADDR_ID)     rdData = ID_VALUE;
    else                                 rdData = 8'h00;
  end

  assign irqPending = |status;

  // R9: a committed write to a read/write byte lands there
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    wrIsRw |=> regs[$past(wrIdx)] == $past(strb.wrData));

  // R7 / R8: writes outside the read/write and event bytes leave the bytes alone
  a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !(strb.wrAddr < RW_LIMIT)) |=> $stable(cfgOut));

  // R10: bits written as 1 are cleared unless an event sets them again
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrAddr == ADDR_STATUS) |=>
      ((status & $past(strb.wrData) & ~$past(evtIn)) == 8'h00));

  // R10: without a write to the event byte, no set bit drops
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrEn && strb.wrAddr == ADDR_STATUS) |=>
      ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hostPortPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_RW      = 8,
  parameter logic       ID_VARIANT  = 1'b1,
  parameter logic [2:0] ID_CODE     = 3'b010,
  parameter logic [3:0] ID_REV      = 4'h3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                muxSel,
  input  logic                busTypeSel,
  input  logic                testHiZ,
  input  logic                csN,
  input  logic [6:0]          addrLo,
  input  logic                aleA7,
  input  logic                rdDsN,
  input  logic                wrRwN,
  input  logic [7:0]          dbIn,
  output logic [7:0]          dbOut,
  output logic                dbOe,
  input  logic [7:0]          evtIn,
  output logic [8*NUM_RW-1:0] cfgOut,
  output logic                irqN,
  output logic                irqOe
);
  localparam int PIN_W = $bits(busPins_t);

  busPins_t   rawPins;
  busPins_t   syncPins;
  logic [PIN_W-1:0] syncBits;
  regStrobe_t strb;
  logic [7:0] rdData;
  logic       irqPending;

  assign rawPins = '{csN: csN, aleA7: aleA7, addrLo: addrLo,
                     rdDsN: rdDsN, wrRwN: wrRwN, data: dbIn};

  hostPortSync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST(PINS_IDLE)) i_sync (
    .clk(clk), .rstN(rstN), .din(rawPins), .dout(syncBits));

  assign syncPins = syncBits;

  hostPortCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .muxSel(muxSel), .busTypeSel(busTypeSel),
    .pins(syncPins), .strb(strb));

  hostPortData #(.NUM_RW(NUM_RW), .ID_VARIANT(ID_VARIANT), .ID_CODE(ID_CODE),
                 .ID_REV(ID_REV)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(evtIn), .rdData(rdData),
    .cfgOut(cfgOut), .irqPending(irqPending));

  assign dbOe  = strb.rdEn && !testHiZ;
  assign dbOut = strb.rdEn ? rdData : 8'h00;
  assign irqN  = !irqPending;
  assign irqOe = !testHiZ;

endmodule

// File: tb/test_hostRegPort.sv
module test_hostRegPort;
  localparam int SYNC = 2;
  localparam int P_CS = 18, P_ALE = 17, P_RD = 9, P_WR = 8;
  localparam logic [18:0] IDLE = {1'b1, 1'b0, 7'h00, 1'b1, 1'b1, 8'h00};

  logic clk = 1'b0, rstN = 1'b0;
  logic muxSel = 1'b0, busTypeSel = 1'b0, testHiZ = 1'b0;
  logic csN = 1'b1, aleA7 = 1'b0, rdDsN = 1'b1, wrRwN = 1'b1;
  logic [6:0] addrLo = 7'h00;
  logic [7:0] dbIn = 8'h00, evtIn = 8'h00;
  logic [7:0] dbOut;
  logic dbOe, irqN, irqOe;
  logic [63:0] cfgOut;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  hostRegPort #(.SYNC_STAGES(SYNC)) i_hostRegPort (
    .clk(clk), .rstN(rstN), .muxSel(muxSel), .busTypeSel(busTypeSel),
    .testHiZ(testHiZ), .csN(csN), .addrLo(addrLo), .aleA7(aleA7),
    .rdDsN(rdDsN), .wrRwN(wrRwN), .dbIn(dbIn), .dbOut(dbOut), .dbOe(dbOe),
    .evtIn(evtIn), .cfgOut(cfgOut), .irqN(irqN), .irqOe(irqOe));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [18:0] hist [0:SYNC];
  logic [7:0]  mRegs [0:7];
  logic [7:0]  mStatus, mLat;

  function automatic logic [7:0] mRead(logic [7:0] a);
    if (a < 8)          return mRegs[a[2:0]];
    else if (a == 8'h08) return mStatus;
    else if (a == 8'h0F) return 8'hA3;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i <= SYNC; i++) hist[i] = IDLE;
      for (int i = 0; i < 8; i++) mRegs[i] = 8'h00;
      mStatus = 8'h00;
      mLat = 8'h00;
    end else begin
      logic [18:0] s, p;
      logic commit;
      logic [7:0] wa, clr;
      s = hist[SYNC-1];
      p = hist[SYNC];
      commit = !p[P_CS] && (busTypeSel ? (s[P_RD] && !p[P_RD] && !p[P_WR])
                                       : (s[P_WR] && !p[P_WR]));
      wa = muxSel ? mLat : p[17:10];
      clr = 8'h00;
      if (commit) begin
        if (wa < 8) mRegs[wa[2:0]] = p[7:0];
        else if (wa == 8'h08) clr = p[7:0];
      end
      mStatus = (mStatus & ~clr) | evtIn;
      if (muxSel && s[P_ALE] && !p[P_ALE]) mLat = s[7:0];
      for (int i = SYNC; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {csN, aleA7, addrLo, rdDsN, wrRwN, dbIn};
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [18:0] s;
      logic rd;
      logic [7:0] a;
      s = hist[SYNC-1];
      rd = !s[P_CS] && (busTypeSel ? (!s[P_RD] && s[P_WR]) : !s[P_RD]);
      a = muxSel ? mLat : s[17:10];
      chk("R6 model dbOe", {7'h0, dbOe}, {7'h0, rd && !testHiZ});
      chk("R9 model dbOut", dbOut, rd ? mRead(a) : 8'h00);
      chk("R10 model irqN", {7'h0, irqN}, {7'h0, ~|mStatus});
      chk("R11 model irqOe", {7'h0, irqOe}, {7'h0, !testHiZ});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic step(int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic setAddr(logic [7:0] a);
    if (muxSel) begin
      addrLo = ~a[6:0];
      aleA7 = 1'b0;
      dbIn = a;
      step(3);
      aleA7 = 1'b1;
      step(3);
      aleA7 = 1'b0;
      dbIn = 8'hE7;
      step(2);
    end else begin
      aleA7 = a[7];
      addrLo = a[6:0];
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d, logic cs);
    setAddr(a);
    dbIn = d;
    csN = cs;
    if (busTypeSel) begin
      wrRwN = 1'b0; step(1);
      rdDsN = 1'b0; step(4);
      rdDsN = 1'b1; step(2);
      wrRwN = 1'b1;
    end else begin
      wrRwN = 1'b0; step(4);
      wrRwN = 1'b1; step(2);
    end
    csN = 1'b1;
    step(2);
  endtask

  task automatic busRead(logic [7:0] a, logic [7:0] exp, string tag);
    setAddr(a);
    csN = 1'b0;
    wrRwN = 1'b1;
    rdDsN = 1'b0;
    step(SYNC + 3);
    @(negedge clk);
    chk({tag, " oe"}, {7'h0, dbOe}, 8'h01);
    chk(tag, dbOut, exp);
    @(posedge clk); #5;
    rdDsN = 1'b1;
    csN = 1'b1;
    step(SYNC + 2);
    @(negedge clk);
    chk("R6 released", {7'h0, dbOe}, 8'h00);
    @(posedge clk); #5;
  endtask

  task automatic setMode(logic m, logic b);
    step(2);
    muxSel = m;
    busTypeSel = b;
    step(3);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    @(negedge clk);
    chk("R12 reset dbOe", {7'h0, dbOe}, 8'h00);
    chk("R12 reset irqN", {7'h0, irqN}, 8'h01);
    chk("R12 reset cfg0", cfgOut[7:0], 8'h00);
    @(posedge clk); #5;
    busRead(8'h04, 8'h00, "R12 reset reg4");

    // separate address, read/write strobes
    setMode(1'b0, 1'b0);
    busWrite(8'h03, 8'h5A, 1'b0);
    busRead(8'h03, 8'h5A, "R3 R9 write/read reg3");
    chk("R9 cfgOut byte3", cfgOut[31:24], 8'h5A);
    busWrite(8'h83, 8'hC1, 1'b0);
    busRead(8'h03, 8'h5A, "R1 top bit separates 0x83");
    busRead(8'h83, 8'h00, "R1 R8 read 0x83");
    busWrite(8'h0F, 8'h00, 1'b0);
    busRead(8'h0F, 8'hA3, "R7 identity");
    busWrite(8'h0B, 8'hFF, 1'b0);
    busRead(8'h0B, 8'h00, "R8 unused 0x0B");
    busRead(8'hBD, 8'h00, "R8 unused 0xBD");
    busWrite(8'h03, 8'h11, 1'b1);
    busRead(8'h03, 8'h5A, "R5 write without select");
    setAddr(8'h03);
    rdDsN = 1'b0;
    step(SYNC + 3);
    @(negedge clk);
    chk("R5 R6 read without select", {7'h0, dbOe}, 8'h00);
    @(posedge clk); #5;
    rdDsN = 1'b1;
    step(2);

    // separate address, data strobe with direction
    setMode(1'b0, 1'b1);
    busWrite(8'h05, 8'hC3, 1'b0);
    busRead(8'h05, 8'hC3, "R4 strobe/direction write");
    busRead(8'h03, 8'h5A, "R4 reads leave reg3");

    // shared bus, read/write strobes
    setMode(1'b1, 1'b0);
    busWrite(8'h06, 8'h3C, 1'b0);
    busRead(8'h06, 8'h3C, "R2 latched address");
    busRead(8'h05, 8'hC3, "R2 latched read reg5");
    chk("R9 cfgOut byte6", cfgOut[55:48], 8'h3C);

    // shared bus, data strobe with direction
    setMode(1'b1, 1'b1);
    busWrite(8'h07, 8'h99, 1'b0);
    busRead(8'h07, 8'h99, "R2 R4 shared bus strobe write");
    busRead(8'h0F, 8'hA3, "R7 identity shared bus");

    // sticky events
    setMode(1'b0, 1'b0);
    evtIn = 8'h81; step(1);
    evtIn = 8'h00; step(2);
    @(negedge clk);
    chk("R10 flag set", {7'h0, irqN}, 8'h00);
    @(posedge clk); #5;
    busRead(8'h08, 8'h81, "R10 event byte");
    busWrite(8'h08, 8'h01, 1'b0);
    busRead(8'h08, 8'h80, "R10 partial clear");
    busWrite(8'h08, 8'h80, 1'b0);
    busRead(8'h08, 8'h00, "R10 full clear");
    @(negedge clk);
    chk("R10 flag released", {7'h0, irqN}, 8'h01);
    @(posedge clk); #5;

    // test input during a read
    setAddr(8'h03);
    csN = 1'b0;
    rdDsN = 1'b0;
    step(SYNC + 3);
    testHiZ = 1'b1;
    @(negedge clk);
    chk("R11 bus floats", {7'h0, dbOe}, 8'h00);
    chk("R11 flag floats", {7'h0, irqOe}, 8'h00);
    @(posedge clk); #5;
    testHiZ = 1'b0;
    @(negedge clk);
    chk("R11 bus back", {7'h0, dbOe}, 8'h01);
    chk("R11 data back", dbOut, 8'h5A);
    @(posedge clk); #5;
    rdDsN = 1'b1;
    csN = 1'b1;
    step(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule